// File: doc/BRIEF.md
# FPU Deferred-Trap Exception Queue Controller

This block sequences floating-point exceptions for a 32-bit FPU that keeps a one-entry fault queue. When an FP operation reports an exception, the controller does not trap at once. It remembers that an exception is pending. The next FP operation then takes the trap, and its address and instruction word are latched into the queue. While the queue holds an entry, FP operations, FP loads and FP branches are refused with a sequence-error trap. FP stores still run. A privileged store-queue instruction empties the queue. It emits the entry as one 64-bit doubleword and returns the unit to normal execution.

The decoder presents one instruction per cycle on a valid strobe with a class code. The controller answers one cycle later. It gives a trap request with a trap type, and it also updates the trap-type field, the queue-not-empty flag and the store data. A status-register write port loads the flag and the trap-type field. A read view returns both live values at their fixed bit positions.

Top module: `fpu_trapq_ctrl`

## Requirements
- R1: After reset there is no trap request, the queue flag and the trap-type field are 0, the store strobe is low, and the unit is in normal execution, where every FP class is accepted.
- R2: Class codes are 1 FP operation, 2 FP load, 3 FP branch, 4 FP store (status-register store included), 5 store-queue, and any other value means no FP instruction. Trap codes are 0 none, 1 FPU disabled, 2 FP exception and 3 privileged. Each strobe gives at most one trap, as a single-cycle pulse in the cycle after the strobe, and no strobe means no trap.
- R3: With the FPU disabled, classes 1 to 4 trap with code 1, whatever the queue state.
- R4: An accepted FP operation with its exception flag set, in normal execution, raises no trap. It loads the trap-type field from the exception kind and makes the exception pending.
- R5: With an exception pending and the queue empty, the next FP operation traps with code 2, latches its PC and instruction word into the queue and sets the queue flag. FP loads and FP branches in that state are accepted.
- R6: With the queue flag set, an FP operation, FP load or FP branch traps with code 2 and sets the trap-type field to 4 (sequence error). The queue contents and the flag are left unchanged.
- R7: FP stores with the FPU enabled never trap, whether an exception is pending or queued.
- R8: A store-queue instruction outside supervisor mode traps with code 3, before any other check. In supervisor mode with the FPU disabled it traps with code 1.
- R9: A store-queue instruction with an empty queue traps with code 2 and sets the trap-type field to 4.
- R10: A store-queue instruction with a non-empty queue raises no trap. It pulses the store strobe for one cycle with the address in bits 63:32 (the lower-addressed word) and the instruction word in bits 31:0. It clears the queue flag, clears the trap-type field to 0 and returns to normal execution.
- R11: The status view carries the queue flag at bit 13 and the trap-type field at bits 16:14, with all other bits 0. A status write loads both fields from those positions.
- R12: When a status write and a strobe fall in the same cycle, the strobe is judged on the state held before that cycle. Any field the strobe updates takes the strobe's value, and the write supplies the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insnValid | input | 1 | Instruction strobe |
| insnCls | input | 3 | Instruction class code |
| excSignal | input | 1 | The FP operation reports an exception |
| excKind | input | 3 | Trap-type value for the reported exception |
| pc | input | ADDR_W | Address of the strobed instruction |
| insnWord | input | INSN_W | Encoding of the strobed instruction |
| fpuEnable | input | 1 | FPU enabled |
| supervisor | input | 1 | Supervisor mode |
| fsrWrEn | input | 1 | Status register write enable |
| fsrWrData | input | 32 | Status register write data |
| trapReq | output | 1 | Trap request pulse |
| trapType | output | 3 | Trap code |
| ftt | output | 3 | Trap-type field |
| qne | output | 1 | Queue-not-empty flag |
| fsrRead | output | 32 | Status view of the flag and the field |
| storeValid | output | 1 | Store-queue data strobe |
| storeData | output | ADDR_W+INSN_W | Doubleword drained from the queue |

## Verification
A status-register write and an instruction strobe can reach the controller in the same cycle, and both may target the queue flag and the trap-type field. The bench sends an FP operation that reports an exception together with a write that sets the flag and a different trap-type value. The trap-type field must take the instruction's exception kind and the flag must take the written value. A store-queue issued next must then drain the entry that was captured earlier and return the unit to normal execution.

// File: rtl/fptq_pkg.sv
package fptq_pkg;
  localparam int FSR_W   = 32;
  localparam int QNE_BIT = 13;
  localparam int FTT_LSB = 14;
  localparam int FTT_W   = 3;
  localparam int CLS_W   = 3;
  localparam int TRAP_W  = 3;

  localparam logic [FTT_W-1:0] FTT_SEQ = 3'd4;

  localparam logic [CLS_W-1:0] CLS_FPOP    = 3'd1;
  localparam logic [CLS_W-1:0] CLS_FLOAD   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_FBRANCH = 3'd3;
  localparam logic [CLS_W-1:0] CLS_FSTORE  = 3'd4;
  localparam logic [CLS_W-1:0] CLS_STQ     = 3'd5;

  localparam logic [TRAP_W-1:0] TRAP_NONE   = 3'd0;
  localparam logic [TRAP_W-1:0] TRAP_FPDIS  = 3'd1;
  localparam logic [TRAP_W-1:0] TRAP_FPEXC  = 3'd2;
  localparam logic [TRAP_W-1:0] TRAP_PRIV   = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic             drain;
    logic             loadFtt;
    logic [FTT_W-1:0] fttVal;
  } dp_ctl_t;
endpackage

// File: rtl/fptq_ctrl.sv
module fptq_ctrl
  import fptq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnValid,
  input  logic [CLS_W-1:0]  insnCls,
  input  logic              excSignal,
  input  logic [FTT_W-1:0]  excKind,
  input  logic              fpuEnable,
  input  logic              supervisor,
  input  logic              qne,
  output dp_ctl_t           dpCtl,
  output logic              trapReq,
  output logic [TRAP_W-1:0] trapType
);
  logic              pend, pendNext;
  logic [TRAP_W-1:0] trapNext;

  always_comb begin
    pendNext = pend;
    trapNext = TRAP_NONE;
    dpCtl    = '0;
    if (insnValid) begin
      case (insnCls)
        CLS_FPOP, CLS_FLOAD, CLS_FBRANCH: begin
          if (!fpuEnable) begin
            trapNext = TRAP_FPDIS;
          end else if (qne) begin
            trapNext      = TRAP_FPEXC;
            dpCtl.loadFtt = 1'b1;
            dpCtl.fttVal  = FTT_SEQ;
          end else if (pend && insnCls == CLS_FPOP) begin
            trapNext      = TRAP_FPEXC;
            dpCtl.capture = 1'b1;
            pendNext      = 1'b0;
          end else if (insnCls == CLS_FPOP && excSignal) begin
            pendNext      = 1'b1;
            dpCtl.loadFtt = 1'b1;
            dpCtl.fttVal  = excKind;
          end
        end
        CLS_FSTORE: begin
          if (!fpuEnable) trapNext = TRAP_FPDIS;
        end
        CLS_STQ: begin
          if (!supervisor) begin
            trapNext = TRAP_PRIV;
          end else if (!fpuEnable) begin
            trapNext = TRAP_FPDIS;
          end else if (!qne) begin
            trapNext      = TRAP_FPEXC;
            dpCtl.loadFtt = 1'b1;
            dpCtl.fttVal  = FTT_SEQ;
          end else begin
            dpCtl.drain   = 1'b1;
            dpCtl.loadFtt = 1'b1;
            dpCtl.fttVal  = '0;
            pendNext      = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= 1'b0;
      trapReq  <= 1'b0;
      trapType <= TRAP_NONE;
    end else begin
      pend     <= pendNext;
      trapReq  <= (trapNext != TRAP_NONE);
      trapType <= trapNext;
    end
  end
endmodule

// File: rtl/fptq_data.sv
module fptq_data
  import fptq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  localparam int SD_W  = ADDR_W + INSN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           dpCtl,
  input  logic [ADDR_W-1:0] pc,
  input  logic [INSN_W-1:0] insnWord,
  input  logic              fsrWrEn,
  input  logic [FSR_W-1:0]  fsrWrData,
  output logic              qne,
  output logic [FTT_W-1:0]  ftt,
  output logic              storeValid,
  output logic [SD_W-1:0]   storeData,
  output logic [FSR_W-1:0]  fsrRead
);
  logic [ADDR_W-1:0] addrQ;
  logic [INSN_W-1:0] insnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qne        <= 1'b0;
      ftt        <= '0;
      addrQ      <= '0;
      insnQ      <= '0;
      storeValid <= 1'b0;
      storeData  <= '0;
    end else begin
      storeValid <= dpCtl.drain;
      // status write first; instruction strobes override below
      if (fsrWrEn) begin
        qne <= fsrWrData[QNE_BIT];
        ftt <= fsrWrData[FTT_LSB +: FTT_W];
      end
      if (dpCtl.capture) begin
        addrQ <= pc;
        insnQ <= insnWord;
        qne   <= 1'b1;
      end
      if (dpCtl.drain) begin
        qne       <= 1'b0;
        storeData <= {addrQ, insnQ};
      end
      if (dpCtl.loadFtt) ftt <= dpCtl.fttVal;
    end
  end

  always_comb begin
    fsrRead                       = '0;
    fsrRead[QNE_BIT]              = qne;
    fsrRead[FTT_LSB +: FTT_W]     = ftt;
  end
endmodule

// File: rtl/fpu_trapq_ctrl.sv
module fpu_trapq_ctrl
  import fptq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  localparam int SD_W  = ADDR_W + INSN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnValid,
  input  logic [2:0]        insnCls,
  input  logic              excSignal,
  input  logic [2:0]        excKind,
  input  logic [ADDR_W-1:0] pc,
  input  logic [INSN_W-1:0] insnWord,
  input  logic              fpuEnable,
  input  logic              supervisor,
  input  logic              fsrWrEn,
  input  logic [31:0]       fsrWrData,
  output logic              trapReq,
  output logic [2:0]        trapType,
  output logic [2:0]        ftt,
  output logic              qne,
  output logic [31:0]       fsrRead,
  output logic              storeValid,
  output logic [SD_W-1:0]   storeData
);
  dp_ctl_t dpCtl;

  fptq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .insnValid  (insnValid),
    .insnCls    (insnCls),
    .excSignal  (excSignal),
    .excKind    (excKind),
    .fpuEnable  (fpuEnable),
    .supervisor (supervisor),
    .qne        (qne),
    .dpCtl      (dpCtl),
    .trapReq    (trapReq),
    .trapType   (trapType)
  );

  fptq_data #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .pc         (pc),
    .insnWord   (insnWord),
    .fsrWrEn    (fsrWrEn),
    .fsrWrData  (fsrWrData),
    .qne        (qne),
    .ftt        (ftt),
    .storeValid (storeValid),
    .storeData  (storeData),
    .fsrRead    (fsrRead)
  );
endmodule

// File: rtl/fpu_trapq_chk.sv
module fpu_trapq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       insnValid,
  input logic [2:0] insnCls,
  input logic       fpuEnable,
  input logic       supervisor,
  input logic       fsrWrEn,
  input logic       trapReq,
  input logic [2:0] trapType,
  input logic [2:0] ftt,
  input logic       qne,
  input logic       storeValid
);
  assert_no_strobe_no_trap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !insnValid |=> !trapReq);

  assert_trap_has_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> trapType != 3'd0);

  assert_disabled_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    insnValid && insnCls >= 3'd1 && insnCls <= 3'd4 && !fpuEnable |=> trapType == 3'd1);

  assert_seq_error_R6: assert property (@(posedge clk) disable iff (!rstN)
    qne && insnValid && insnCls >= 3'd1 && insnCls <= 3'd3 && fpuEnable && !fsrWrEn
      |=> trapType == 3'd2 && ftt == 3'd4 && qne);

  assert_store_passes_R7: assert property (@(posedge clk) disable iff (!rstN)
    insnValid && insnCls == 3'd4 && fpuEnable |=> !trapReq);

  assert_priv_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    insnValid && insnCls == 3'd5 && !supervisor |=> trapType == 3'd3);

  assert_drain_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    storeValid |-> !qne && ftt == 3'd0 && $past(qne));
endmodule

bind fpu_trapq_ctrl fpu_trapq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .insnValid  (insnValid),
  .insnCls    (insnCls),
  .fpuEnable  (fpuEnable),
  .supervisor (supervisor),
  .fsrWrEn    (fsrWrEn),
  .trapReq    (trapReq),
  .trapType   (trapType),
  .ftt        (ftt),
  .qne        (qne),
  .storeValid (storeValid)
);

// File: tb/fpu_trapq_ctrl_tb.sv
`timescale 1ns/1ps
module fpu_trapq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        insnValid;
  logic [2:0]  insnCls;
  logic        excSignal;
  logic [2:0]  excKind;
  logic [31:0] pc;
  logic [31:0] insnWord;
  logic        fpuEnable;
  logic        supervisor;
  logic        fsrWrEn;
  logic [31:0] fsrWrData;
  logic        trapReq;
  logic [2:0]  trapType;
  logic [2:0]  ftt;
  logic        qne;
  logic [31:0] fsrRead;
  logic        storeValid;
  logic [63:0] storeData;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fpu_trapq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .insnValid(insnValid), .insnCls(insnCls),
    .excSignal(excSignal), .excKind(excKind), .pc(pc), .insnWord(insnWord),
    .fpuEnable(fpuEnable), .supervisor(supervisor), .fsrWrEn(fsrWrEn),
    .fsrWrData(fsrWrData), .trapReq(trapReq), .trapType(trapType), .ftt(ftt),
    .qne(qne), .fsrRead(fsrRead), .storeValid(storeValid), .storeData(storeData)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] cls;
    logic       sig;
    logic [2:0] kind;
    logic       en;
    logic       sup;
    logic [2:0] expTrap;
    logic       expQne;
    logic [2:0] expFtt;
    logic       expSv;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd4,  3'd1, 1'b1, 3'd2, 1'b1, 1'b1, 3'd0, 1'b0, 3'd2, 1'b0}, // R4 signal
    '{4'd5,  3'd2, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd2, 1'b0}, // R5 load ok
    '{4'd5,  3'd3, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd2, 1'b0}, // R5 branch ok
    '{4'd5,  3'd1, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 1'b1, 3'd2, 1'b0}, // R5 capture
    '{4'd6,  3'd1, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 1'b1, 3'd4, 1'b0}, // R6 fpop
    '{4'd6,  3'd2, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 1'b1, 3'd4, 1'b0}, // R6 load
    '{4'd7,  3'd4, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b1, 3'd4, 1'b0}, // R7 store
    '{4'd3,  3'd3, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd4, 1'b0}, // R3 disabled
    '{4'd8,  3'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd3, 1'b1, 3'd4, 1'b0}, // R8 priv
    '{4'd8,  3'd5, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd4, 1'b0}, // R8 disabled
    '{4'd10, 3'd5, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1}, // R10 drain
    '{4'd9,  3'd5, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 1'b0, 3'd4, 1'b0}, // R9 empty
    '{4'd2,  3'd1, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd4, 1'b0}, // R2 plain op
    '{4'd3,  3'd4, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, 3'd4, 1'b0}, // R3 store off
    '{4'd2,  3'd0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd4, 1'b0}  // R2 none
  };

  localparam logic [63:0] CAP_DW = {32'h4000_000C, 32'h8100_0003};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] cls, input logic sig, input logic [2:0] kind,
                        input logic en, input logic sup, input logic [31:0] p,
                        input logic [31:0] w, input logic wr, input logic [31:0] wd);
    insnValid = 1'b1; insnCls = cls; excSignal = sig; excKind = kind;
    fpuEnable = en; supervisor = sup; pc = p; insnWord = w;
    fsrWrEn = wr; fsrWrData = wd;
    @(posedge clk);
    @(negedge clk);
    insnValid = 1'b0; fsrWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rstN = 1'b0; insnValid = 1'b0; insnCls = '0; excSignal = 1'b0; excKind = '0;
    pc = '0; insnWord = '0; fpuEnable = 1'b1; supervisor = 1'b1;
    fsrWrEn = 1'b0; fsrWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 trapReq", trapReq, 0);
    check("R1 qne", qne, 0);
    check("R1 ftt", ftt, 0);
    check("R1 storeValid", storeValid, 0);
    check("R1 fsrRead", fsrRead, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      strobe(TBL[i].cls, TBL[i].sig, TBL[i].kind, TBL[i].en, TBL[i].sup,
             32'h4000_0000 + 32'(i * 4), 32'h8100_0000 + 32'(i), 1'b0, '0);
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      check({tag, " trapType"}, trapType, TBL[i].expTrap);
      check({tag, " trapReq"}, trapReq, TBL[i].expTrap != 3'd0);
      check({tag, " qne"}, qne, TBL[i].expQne);
      check({tag, " ftt"}, ftt, TBL[i].expFtt);
      check({tag, " storeValid"}, storeValid, TBL[i].expSv);
      if (TBL[i].expSv) check({tag, " storeData"}, storeData, CAP_DW);
      @(negedge clk);
      check({tag, " pulse"}, trapReq, 0); // R2 single-cycle
    end

    // R11 status write and view
    strobe(3'd0, 1'b0, 3'd0, 1'b1, 1'b1, '0, '0, 1'b1, 32'h0001_A000);
    check("R11 fsrRead", fsrRead, 32'h0001_A000);
    check("R11 qne", qne, 1);
    strobe(3'd1, 1'b0, 3'd0, 1'b1, 1'b1, 32'h5000_0000, 32'hDEAD_0000, 1'b0, '0);
    check("R6 after write trapType", trapType, 2);
    check("R6 after write fsrRead", fsrRead, 32'h0001_2000);
    strobe(3'd0, 1'b0, 3'd0, 1'b1, 1'b1, '0, '0, 1'b1, 32'h0000_0000);
    check("R11 cleared", fsrRead, 0);

    // R12 write and strobe together: ftt from instruction, qne from write
    strobe(3'd1, 1'b1, 3'd3, 1'b1, 1'b1, 32'h6000_0000, 32'hBEEF_0000, 1'b1, 32'h0001_A000);
    check("R12 trapType", trapType, 0);
    check("R12 fsrRead", fsrRead, 32'h0000_E000);
    strobe(3'd5, 1'b0, 3'd0, 1'b1, 1'b1, '0, '0, 1'b0, '0);
    check("R12 drain strobe", storeValid, 1);
    check("R12 drain data", storeData, CAP_DW);
    check("R12 drain fsr", fsrRead, 0);
    strobe(3'd1, 1'b0, 3'd0, 1'b1, 1'b1, 32'h7000_0000, 32'h1, 1'b0, '0);
    check("R10 back to execute", trapReq, 0);
    summary();
  end
endmodule